// File: doc/BRIEF.md
# FIFO Flag Offset Configuration Unit

This unit holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. The almost-empty offset is a distance from the empty boundary and the almost-full offset is a distance from the full boundary. The flag logic itself lives elsewhere. The unit only produces the two offsets and a done indication.

During a full reset the unit samples two strap inputs. Three of the four codes give a fixed offset, and the same value goes to both fields. The fourth code leaves the offsets open to programming. A third strap, sampled at the same time, chooses how programming is done:

- **Parallel:** two writes on the low bits of the write data port.
- **Serial:** a bit stream on a dedicated serial input.

Once configuration is complete, write strobes pass through to the FIFO. A partial reset, used for flushing the FIFO, leaves everything in this unit as it was.

All registers use a synchronous full reset. An output changes on the clock edge that takes the event causing it. The defaults use offsets up to 64, so the offset width must be at least 7 bits. The default depth of 256 gives 8-bit fields.

Top module: `flag_offset_cfg`

## Requirements
- R1: While full reset is held (rst_n low at a clock edge), strap code 2'b00, 2'b01 and 2'b10 set both offsets to 8, 16 and 64 respectively, and cfg_done to 1.
- R2: Strap code 2'b11 at full reset sets both offsets to 0 and cfg_done to 0, which arms programming.
- R3: prog_serial_strap sampled at full reset selects the method, 1 for serial and 0 for parallel. In serial mode wr_en never changes an offset, and in parallel mode ser_en never changes an offset.
- R4: In parallel mode, the first write accepted while unconfigured loads wr_data into the almost-empty offset. The second loads the almost-full offset and sets cfg_done. Both take effect on the edge of the write.
- R5: In serial mode, each edge with ser_en high shifts in one bit, and edges with ser_en low are skipped. The stream carries 2*OFS_W bits: the almost-empty offset first and then the almost-full offset, each MSB first. Both offsets and cfg_done update together on the edge of the last bit, and not before.
- R6: Once cfg_done is 1, further wr_en or ser_en activity leaves both offsets unchanged.
- R7: fifo_wr equals wr_en when cfg_done is 1 and is 0 while cfg_done is 0.
- R8: While prst_n is low, the offsets, cfg_done, the programming method and any partly received programming are held, and programming inputs are ignored. After prst_n returns high, programming resumes where it stopped, and a completed configuration is kept rather than returned to defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, synchronous; straps are sampled while low |
| prst_n | input | 1 | Partial reset, active low; configuration is held while low |
| dflt_sel | input | 2 | Default offset strap: 00=8, 01=16, 10=64, 11=program |
| prog_serial_strap | input | 1 | Programming method strap: 1 serial, 0 parallel |
| wr_en | input | 1 | Write strobe of the FIFO write port |
| wr_data | input | OFS_W | Low bits of the write data port, used for parallel loading |
| ser_en | input | 1 | Serial bit qualifier |
| ser_din | input | 1 | Serial programming data |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| cfg_done | output | 1 | Configuration complete |
| fifo_wr | output | 1 | Write strobe passed on to the FIFO |

## Verification
The hardest state to reach is a serial load interrupted partway through. In that state the shift register holds a partial field. The stimulus needs a partial reset during which ser_en keeps toggling with misleading data. The bench shifts in the almost-empty half, pulses prst_n low for several cycles while driving bits, then finishes the stream. Only the exact expected pair of offsets proves that no bit was taken or lost. The bench also drops ser_en for single cycles inside a stream to show those edges are skipped. It holds the stream one bit short of complete to show that neither offset moves early.

// File: rtl/foc_pkg.sv
package foc_pkg;

  localparam logic [1:0] CODE_PROG = 2'b11;

  typedef enum logic {
    PROG_PARALLEL = 1'b0,
    PROG_SERIAL   = 1'b1
  } prog_mode_e;

  // Default threshold distance selected by the strap code; 0 when programming.
  function automatic int unsigned default_ofs(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 0;
    endcase
  endfunction

  // True on the shift that completes a stream of total_bits bits.
  function automatic logic is_last_bit(input int unsigned count,
                                       input int unsigned total_bits);
    return count == total_bits - 1;
  endfunction

endpackage

// File: rtl/foc_strap_decode.sv
module foc_strap_decode #(
  parameter int OFS_W = 8
) (
  input  logic [1:0]       code,
  output logic [OFS_W-1:0] def_ofs,
  output logic             needs_prog
);
  import foc_pkg::*;

  always_comb begin
    def_ofs    = OFS_W'(default_ofs(code));
    needs_prog = (code == CODE_PROG);
  end
endmodule

// File: rtl/foc_par_loader.sv
module foc_par_loader #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  output logic             ld_ae,
  output logic             ld_af,
  output logic [OFS_W-1:0] ld_val
);
  logic second_q;

  always_comb begin
    ld_ae  = arm && wr_en && !second_q;
    ld_af  = arm && wr_en && second_q;
    ld_val = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     second_q <= 1'b0;
    else if (ld_ae) second_q <= 1'b1;
  end
endmodule

// File: rtl/foc_ser_loader.sv
module foc_ser_loader #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic             ld_both,
  output logic [OFS_W-1:0] ae_val,
  output logic [OFS_W-1:0] af_val
);
  import foc_pkg::*;

  localparam int TOT = 2 * OFS_W;
  localparam int CW  = $clog2(TOT + 1);

  logic [TOT-2:0] sh_q;
  logic [CW-1:0]  cnt_q;
  logic [TOT-1:0] word;
  logic           step;

  always_comb begin
    step    = arm && ser_en;
    word    = {sh_q, ser_din};
    ld_both = step && is_last_bit(int'(cnt_q), TOT);
    ae_val  = word[TOT-1:OFS_W];
    af_val  = word[OFS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (step) begin
      sh_q  <= word[TOT-2:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/flag_offset_cfg.sv
module flag_offset_cfg #(
  parameter int DEPTH = 256,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prst_n,
  input  logic [1:0]       dflt_sel,
  input  logic             prog_serial_strap,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             ser_en,
  input  logic             ser_din,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic             cfg_done,
  output logic             fifo_wr
);
  import foc_pkg::*;

  prog_mode_e       mode_q;
  logic [OFS_W-1:0] ae_q, af_q;
  logic             done_q;

  logic [OFS_W-1:0] def_ofs;
  logic             needs_prog;
  logic             par_arm, ser_arm;
  logic             par_ae_ld, par_af_ld, ser_ld;
  logic [OFS_W-1:0] par_val, ser_ae, ser_af;

  foc_strap_decode #(.OFS_W(OFS_W)) u_dec (
    .code(dflt_sel), .def_ofs(def_ofs), .needs_prog(needs_prog)
  );

  always_comb begin
    par_arm = !done_q && prst_n && (mode_q == PROG_PARALLEL);
    ser_arm = !done_q && prst_n && (mode_q == PROG_SERIAL);
  end

  foc_par_loader #(.OFS_W(OFS_W)) u_par (
    .clk(clk), .rst_n(rst_n), .arm(par_arm), .wr_en(wr_en), .wr_data(wr_data),
    .ld_ae(par_ae_ld), .ld_af(par_af_ld), .ld_val(par_val)
  );

  foc_ser_loader #(.OFS_W(OFS_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .arm(ser_arm), .ser_en(ser_en), .ser_din(ser_din),
    .ld_both(ser_ld), .ae_val(ser_ae), .af_val(ser_af)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= prog_serial_strap ? PROG_SERIAL : PROG_PARALLEL;
      ae_q   <= def_ofs;
      af_q   <= def_ofs;
      done_q <= !needs_prog;
    end else begin
      if (par_ae_ld) ae_q <= par_val;
      if (par_af_ld) begin
        af_q   <= par_val;
        done_q <= 1'b1;
      end
      if (ser_ld) begin
        ae_q   <= ser_ae;
        af_q   <= ser_af;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ae_ofs   = ae_q;
    af_ofs   = af_q;
    cfg_done = done_q;
    fifo_wr  = wr_en && done_q;
  end
endmodule

// File: rtl/flag_offset_cfg_chk.sv
module flag_offset_cfg_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prst_n,
  input logic             wr_en,
  input logic             ser_en,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs,
  input logic             cfg_done,
  input logic             fifo_wr,
  input logic             par_ae_ld,
  input logic             par_af_ld,
  input logic             ser_ld
);
  // R6
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(ae_ofs) && $stable(af_ofs)));

  // R8
  prst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(cfg_done)));

  // R4
  done_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(wr_en || ser_en));

  // R7
  no_early_fifo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !fifo_wr);

  // R3
  single_loader_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({par_ae_ld, par_af_ld, ser_ld}));

  // R5
  ser_load_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ld |=> cfg_done);
endmodule

bind flag_offset_cfg flag_offset_cfg_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .wr_en(wr_en), .ser_en(ser_en),
  .ae_ofs(ae_ofs), .af_ofs(af_ofs), .cfg_done(cfg_done), .fifo_wr(fifo_wr),
  .par_ae_ld(par_ae_ld), .par_af_ld(par_af_ld), .ser_ld(ser_ld)
);

// File: tb/tb_flag_offset_cfg.sv
`timescale 1ns/1ps
module tb_flag_offset_cfg;
  localparam int OFS_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1;
  logic [1:0] dflt_sel = 2'b00;
  logic prog_serial_strap = 1'b0;
  logic wr_en = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic [OFS_W-1:0] wr_data = '0;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic cfg_done, fifo_wr;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flag_offset_cfg #(.DEPTH(256)) dut (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .dflt_sel(dflt_sel),
    .prog_serial_strap(prog_serial_strap), .wr_en(wr_en), .wr_data(wr_data),
    .ser_en(ser_en), .ser_din(ser_din), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .cfg_done(cfg_done), .fifo_wr(fifo_wr)
  );

  // {code, serial strap, expected offset, expected done}
  localparam logic [11:0] VEC [4] = '{
    {2'b00, 1'b0, 8'd8,  1'b1},
    {2'b01, 1'b1, 8'd16, 1'b1},
    {2'b10, 1'b0, 8'd64, 1'b1},
    {2'b11, 1'b0, 8'd0,  1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic full_reset(input logic [1:0] code, input logic smode);
    @(negedge clk);
    rst_n = 1'b0; dflt_sel = code; prog_serial_strap = smode;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; dflt_sel = 2'b00; prog_serial_strap = ~smode;
  endtask

  task automatic pwrite(input logic [OFS_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); ser_en = 1'b1; ser_din = b;
    @(negedge clk); ser_en = 1'b0; ser_din = ~b;
  endtask

  task automatic sfield(input logic [OFS_W-1:0] v);
    for (int i = OFS_W - 1; i >= 0; i--) sbit(v[i]);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 R2: defaults from the straps, walked from the table
    for (int k = 0; k < 4; k++) begin
      full_reset(VEC[k][11:10], VEC[k][9]);
      check("R1/R2 ae default", int'(ae_ofs), int'(VEC[k][8:1]));
      check("R1/R2 af default", int'(af_ofs), int'(VEC[k][8:1]));
      check("R1/R2 done",       int'(cfg_done), int'(VEC[k][0]));
    end

    // R4 R7: parallel programming
    full_reset(2'b11, 1'b0);
    @(negedge clk); wr_en = 1'b1; #0.5;
    check("R7 fifo_wr blocked", int'(fifo_wr), 0);
    @(negedge clk); wr_en = 1'b0;           // that write loaded ae = 0
    full_reset(2'b11, 1'b0);
    sbit(1'b1); sbit(1'b1);                 // R3 serial ignored in parallel mode
    check("R3 ser_en ignored ae", int'(ae_ofs), 0);
    pwrite(8'h23);
    check("R4 ae after first write", int'(ae_ofs), 8'h23);
    check("R4 done after first write", int'(cfg_done), 0);
    check("R4 af after first write", int'(af_ofs), 0);
    pwrite(8'hF0);
    check("R4 af after second write", int'(af_ofs), 8'hF0);
    check("R4 done after second", int'(cfg_done), 1);
    pwrite(8'h55);
    check("R6 ae frozen", int'(ae_ofs), 8'h23);
    check("R6 af frozen", int'(af_ofs), 8'hF0);
    @(negedge clk); wr_en = 1'b1; #0.5;
    check("R7 fifo_wr passes", int'(fifo_wr), 1);
    @(negedge clk); wr_en = 1'b0;
    // R8: partial reset after completion keeps the programmed values
    @(negedge clk); prst_n = 1'b0;
    @(negedge clk); @(negedge clk); prst_n = 1'b1;
    @(negedge clk);
    check("R8 ae kept", int'(ae_ofs), 8'h23);
    check("R8 af kept", int'(af_ofs), 8'hF0);
    check("R8 done kept", int'(cfg_done), 1);

    // R3 R5: serial programming with skipped edges
    full_reset(2'b11, 1'b1);
    pwrite(8'h77);
    check("R3 wr_en ignored ae", int'(ae_ofs), 0);
    check("R3 wr_en ignored done", int'(cfg_done), 0);
    sfield(8'hA5);
    @(negedge clk); ser_din = 1'b1;          // ser_en low: skipped
    @(negedge clk);
    for (int i = OFS_W - 1; i >= 1; i--) sbit(8'h3C >> i);
    check("R5 not done one bit short", int'(cfg_done), 0);
    check("R5 ae not early", int'(ae_ofs), 0);
    sbit(1'b0);
    check("R5 ae serial", int'(ae_ofs), 8'hA5);
    check("R5 af serial", int'(af_ofs), 8'h3C);
    check("R5 done serial", int'(cfg_done), 1);
    sfield(8'hFF);
    check("R6 serial frozen", int'(ae_ofs), 8'hA5);

    // R8: partial reset in the middle of a serial stream
    full_reset(2'b11, 1'b1);
    sfield(8'h96);
    @(negedge clk); prst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      ser_en = 1'b1; ser_din = i[0];
      @(negedge clk);
    end
    ser_en = 1'b0; prst_n = 1'b1;
    check("R8 mid-stream done held", int'(cfg_done), 0);
    sfield(8'h5B);
    check("R8 resumed ae", int'(ae_ofs), 8'h96);
    check("R8 resumed af", int'(af_ofs), 8'h5B);
    check("R8 resumed done", int'(cfg_done), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule